// File: doc/BRIEF.md
# Frame-memory rectangle transfer sequencer

This block moves a rectangle of 16-bit pixels between a 32-bit word stream and a frame memory of 1024 columns by 512 rows, in either direction. A one-cycle start pulse delivers a placement word, a dimension word and a direction flag. After that, a write transfer takes words on a valid/ready input stream and stores their two pixels. A read transfer fetches pixels and offers them two per word on a valid/ready output stream. The block walks the rectangle in raster order and wraps both edges of the frame. It drives a single-port pixel memory whose read data arrives one cycle after the address.

Either stream may pause at any word boundary. The walker keeps its column and row, so a pause or a word that straddles two rows costs nothing but time. Input back-pressure: a word is taken only in a cycle where `in_valid` and `in_ready` are both high. Output back-pressure: `out_valid` stays high and `out_data` stays unchanged until `out_ready` is seen high at a clock edge. A start pulse has priority over everything else and abandons any transfer still in progress.

Top module: `rect_xfer_seq`

## Requirements
- R1: The start column is placement-word bits [X_BITS-1:0] and the start row is placement-word bits [16+Y_BITS-1:16]. All other placement bits are ignored.
- R2: The width is ((dimension bits [X_BITS-1:0] − 1) mod 2^X_BITS) + 1 and the height is ((dimension bits [16+Y_BITS-1:16] − 1) mod 2^Y_BITS) + 1. A zero field therefore means the full frame extent, and the other dimension bits are ignored.
- R3: Pixel (x, y) is stored at memory address y·2^X_BITS + x. In every data word, bits [15:0] hold the earlier pixel in raster order and bits [31:16] hold the later one.
- R4: Pixels are visited left to right, then row by row. The column wraps modulo 2^X_BITS and the row wraps modulo 2^Y_BITS.
- R5: While `mask_force` is 1, every pixel written to memory has bit 15 set to 1. The other bits are unchanged.
- R6: During a write transfer, `in_ready` is high only while a word is awaited. It stays high until a word is taken. A stall of any length leaves the rectangle position unchanged.
- R7: During a read transfer, a word offered on `out_data` stays valid and stable until it is accepted.
- R8: When the pixel count is odd, a write ignores bits [31:16] of the final word, and a read returns 0 in those bits.
- R9: `data_ready` rises with the start of a read transfer and falls once the final word has been accepted. No memory write occurs while it is high.
- R10: A start pulse during an active transfer replaces it. The unfinished part of the old rectangle is never touched and produces no done pulse.
- R11: `done` pulses for one cycle when a transfer completes: after the final memory write for a write, after acceptance of the final word for a read. `busy` is low in that cycle.
- R12: After reset, `busy`, `in_ready`, `out_valid`, `data_ready`, `done` and `mem_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that loads a new transfer |
| start_dir | input | 1 | 1 = read from memory, 0 = write to memory |
| start_pos | input | WORD_W | Placement word (column, row) |
| start_size | input | WORD_W | Dimension word (width, height) |
| mask_force | input | 1 | Forces bit 15 of written pixels to 1 |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | WORD_W | Input word, two pixels |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | WORD_W | Output word, two pixels |
| busy | output | 1 | A transfer is active |
| data_ready | output | 1 | A read transfer is active |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | X_BITS+Y_BITS | Pixel memory address |
| mem_wdata | output | PIX_W | Pixel memory write data |
| mem_we | output | 1 | Pixel memory write enable |
| mem_rdata | input | PIX_W | Pixel memory read data, one cycle after the address |

## Verification
Every width from 1 to 6 is combined with every height from 1 to 3 on a 32×16 frame. Each rectangle is written and then read back, which separates odd pixel counts (a padded or ignored final halfword) from even ones, and single-pixel rows from words that straddle two rows. Rectangles placed at the right and bottom edges test the wrap-around. Zero dimension fields test the full-frame extent, and junk in the unused placement and dimension bits must not move or resize a transfer. Stalls on both streams are inserted between words, the mask bit is set on selected writes, and a write abandoned after two words shows that the remaining pixels are never written.

// File: rtl/rect_xfer_pkg.sv
package rect_xfer_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WTAKE,
    S_WLO,
    S_WHI,
    S_RLO,
    S_RHI,
    S_RCAP,
    S_ROUT
  } lane_state_t;
endpackage

// File: rtl/rect_geom.sv
module rect_geom #(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] pos_word,
  input  logic [WORD_W-1:0] size_word,
  output logic [X_BITS-1:0] x0,
  output logic [Y_BITS-1:0] y0,
  output logic [X_BITS:0]   width,
  output logic [Y_BITS:0]   height
);
  localparam int YOFF = WORD_W / 2;

  logic [X_BITS-1:0] w_m1;
  logic [Y_BITS-1:0] h_m1;
  logic unused_bits;

  always_comb begin
    x0     = pos_word[X_BITS-1:0];
    y0     = pos_word[YOFF +: Y_BITS];
    w_m1   = size_word[X_BITS-1:0] - 1'b1;
    h_m1   = size_word[YOFF +: Y_BITS] - 1'b1;
    width  = {1'b0, w_m1} + 1'b1;
    height = {1'b0, h_m1} + 1'b1;
  end

  assign unused_bits = ^{pos_word[WORD_W-1:YOFF+Y_BITS], pos_word[YOFF-1:X_BITS],
                         size_word[WORD_W-1:YOFF+Y_BITS], size_word[YOFF-1:X_BITS]};
endmodule

// File: rtl/rect_walker.sv
module rect_walker #(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [X_BITS-1:0]        x0,
  input  logic [Y_BITS-1:0]        y0,
  input  logic [X_BITS:0]          width,
  input  logic [Y_BITS:0]          height,
  input  logic                     step,
  output logic [X_BITS+Y_BITS-1:0] addr,
  output logic                     last
);
  localparam logic [X_BITS:0] ONE_COL = 1;
  localparam logic [Y_BITS:0] ONE_ROW = 1;

  logic [X_BITS-1:0] x0_q;
  logic [X_BITS-1:0] col_q;
  logic [X_BITS:0]   w_q;
  logic [Y_BITS-1:0] y_q;
  logic [Y_BITS:0]   rows_q;
  logic              row_end;
  logic [X_BITS-1:0] x_cur;

  always_comb begin
    row_end = ({1'b0, col_q} == (w_q - ONE_COL));
    last    = row_end && (rows_q == ONE_ROW);
    x_cur   = x0_q + col_q;
    addr    = {y_q, x_cur};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0_q   <= '0;
      col_q  <= '0;
      w_q    <= ONE_COL;
      y_q    <= '0;
      rows_q <= '0;
    end else if (load) begin
      x0_q   <= x0;
      col_q  <= '0;
      w_q    <= width;
      y_q    <= y0;
      rows_q <= height;
    end else if (step) begin
      if (row_end) begin
        col_q  <= '0;
        y_q    <= y_q + 1'b1;
        rows_q <= rows_q - ONE_ROW;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  // R4: the column offset never leaves the row while rows remain
  assert_col_in_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rows_q != '0) |-> ({1'b0, col_q} < w_q));

  // R4: no pixel is stepped past the end of the rectangle
  assert_step_in_rect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> (rows_q != '0));
endmodule

// File: rtl/rect_lane_ctrl.sv
module rect_lane_ctrl
  import rect_xfer_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_dir,
  input  logic               walk_last,
  input  logic               mask_force,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2*PIX_W-1:0] in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [2*PIX_W-1:0] out_data,
  input  logic [PIX_W-1:0]   mem_rdata,
  output logic [PIX_W-1:0]   mem_wdata,
  output logic               mem_we,
  output logic               step,
  output logic               busy,
  output logic               data_ready,
  output logic               done
);
  localparam int WORD_W = 2 * PIX_W;

  lane_state_t       state_q;
  logic              dir_q;
  logic              lo_last_q;
  logic              fin_q;
  logic              done_q;
  logic [WORD_W-1:0] word_q;
  logic [PIX_W-1:0]  mask_bits;

  always_comb begin
    mask_bits  = {mask_force, {(PIX_W-1){1'b0}}};
    mem_we     = (state_q == S_WLO) || (state_q == S_WHI);
    mem_wdata  = ((state_q == S_WHI) ? word_q[WORD_W-1:PIX_W] : word_q[PIX_W-1:0]) | mask_bits;
    step       = mem_we || (state_q == S_RLO) || ((state_q == S_RHI) && !lo_last_q);
    in_ready   = (state_q == S_WTAKE);
    out_valid  = (state_q == S_ROUT);
    out_data   = word_q;
    busy       = (state_q != S_IDLE);
    data_ready = busy && dir_q;
    done       = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      dir_q     <= 1'b0;
      lo_last_q <= 1'b0;
      fin_q     <= 1'b0;
      done_q    <= 1'b0;
      word_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        dir_q   <= start_dir;
        fin_q   <= 1'b0;
        state_q <= start_dir ? S_RLO : S_WTAKE;
      end else begin
        case (state_q)
          S_WTAKE: if (in_valid) begin
            word_q  <= in_data;
            state_q <= S_WLO;
          end
          S_WLO: begin
            state_q <= walk_last ? S_IDLE : S_WHI;
            done_q  <= walk_last;
          end
          S_WHI: begin
            state_q <= walk_last ? S_IDLE : S_WTAKE;
            done_q  <= walk_last;
          end
          S_RLO: begin
            lo_last_q <= walk_last;
            state_q   <= S_RHI;
          end
          S_RHI: begin
            word_q[PIX_W-1:0] <= mem_rdata;
            if (lo_last_q) begin
              word_q[WORD_W-1:PIX_W] <= '0;
              fin_q   <= 1'b1;
              state_q <= S_ROUT;
            end else begin
              fin_q   <= walk_last;
              state_q <= S_RCAP;
            end
          end
          S_RCAP: begin
            word_q[WORD_W-1:PIX_W] <= mem_rdata;
            state_q <= S_ROUT;
          end
          S_ROUT: if (out_ready) begin
            state_q <= fin_q ? S_IDLE : S_RLO;
            done_q  <= fin_q;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  // R6: an awaited input word stays awaited until it arrives
  assert_ready_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid && !start) |=> in_ready);

  // R7: an offered output word is held stable until accepted
  assert_out_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));

  // R9: a read transfer never writes memory
  assert_read_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> !mem_we);

  // R11: completion pulse coincides with the return to idle
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11: the pulse lasts exactly one cycle
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/rect_xfer_seq.sv
module rect_xfer_seq #(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  parameter int PIX_W  = 16,
  localparam int WORD_W = 2 * PIX_W,
  localparam int AW     = X_BITS + Y_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_dir,
  input  logic [WORD_W-1:0] start_pos,
  input  logic [WORD_W-1:0] start_size,
  input  logic              mask_force,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              busy,
  output logic              data_ready,
  output logic              done,
  output logic [AW-1:0]     mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  output logic              mem_we,
  input  logic [PIX_W-1:0]  mem_rdata
);
  logic [X_BITS-1:0] g_x0;
  logic [Y_BITS-1:0] g_y0;
  logic [X_BITS:0]   g_w;
  logic [Y_BITS:0]   g_h;
  logic              walk_step;
  logic              walk_last;

  rect_geom #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .WORD_W(WORD_W)) u_geom (
    .pos_word  (start_pos),
    .size_word (start_size),
    .x0        (g_x0),
    .y0        (g_y0),
    .width     (g_w),
    .height    (g_h)
  );

  rect_walker #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .x0     (g_x0),
    .y0     (g_y0),
    .width  (g_w),
    .height (g_h),
    .step   (walk_step),
    .addr   (mem_addr),
    .last   (walk_last)
  );

  rect_lane_ctrl #(.PIX_W(PIX_W)) u_lane (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_dir  (start_dir),
    .walk_last  (walk_last),
    .mask_force (mask_force),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .mem_rdata  (mem_rdata),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .step       (walk_step),
    .busy       (busy),
    .data_ready (data_ready),
    .done       (done)
  );

  // R5: forced mask bit appears on every memory write
  assert_mask_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_force && mem_we) |-> mem_wdata[PIX_W-1]);

  // R12: no memory write and no stream activity while idle
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !in_ready && !out_valid));
endmodule

// File: tb/rect_xfer_seq_test.sv
`timescale 1ns/1ps
module rect_xfer_seq_test;
  localparam int XB = 5;
  localparam int YB = 4;
  localparam int NX = 1 << XB;
  localparam int NY = 1 << YB;
  localparam int MEMN = NX * NY;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic start_dir = 1'b0;
  logic [31:0] start_pos = '0;
  logic [31:0] start_size = '0;
  logic mask_force = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [31:0] out_data;
  logic busy, data_ready, done;
  logic [XB+YB-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic mem_we;
  logic [15:0] mem_rdata = '0;

  logic [15:0] mem [0:MEMN-1];
  logic [15:0] exp_mem [0:MEMN-1];
  int checks = 0;
  int errors = 0;
  int done_cnt = 0;

  always #5 clk = ~clk;

  rect_xfer_seq #(.X_BITS(XB), .Y_BITS(YB), .PIX_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
    .start_pos(start_pos), .start_size(start_size), .mask_force(mask_force),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .busy(busy), .data_ready(data_ready), .done(done),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int ext_w(input int f); return ((f - 1) & (NX - 1)) + 1; endfunction
  function automatic int ext_h(input int f); return ((f - 1) & (NY - 1)) + 1; endfunction
  function automatic int paddr(input int x0, input int y0, input int w, input int i);
    return (((y0 + i / w) % NY) * NX) + ((x0 + i % w) % NX);
  endfunction
  function automatic logic [15:0] pval(input int seed, input int i);
    return 16'((seed * 37 + i * 11 + 5) & 32'h7fff);
  endfunction

  task automatic do_start(input logic [31:0] pos, input logic [31:0] size, input bit dir);
    @(negedge clk);
    start = 1'b1; start_pos = pos; start_size = size; start_dir = dir;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < MEMN; i++) if (mem[i] !== exp_mem[i]) bad++;
    check(bad == 0, req, "memory pixel mismatches", bad, 0);
  endtask

  task automatic send_words(input int x0, input int y0, input int w, input int n, input int seed,
                            input bit msk, input int gap, input int maxw);
    int nw = (n + 1) / 2;
    if (maxw < nw) nw = maxw;
    for (int k = 0; k < nw; k++) begin
      logic [15:0] lo, hi;
      lo = pval(seed, 2 * k);
      hi = (2 * k + 1 < n) ? pval(seed, 2 * k + 1) : 16'hBEEF;
      exp_mem[paddr(x0, y0, w, 2 * k)] = lo | (msk ? 16'h8000 : 16'h0000);
      if (2 * k + 1 < n) exp_mem[paddr(x0, y0, w, 2 * k + 1)] = hi | (msk ? 16'h8000 : 16'h0000);
      in_valid = 1'b0;
      if (gap != 0) repeat ((k % 3) * gap) @(negedge clk);
      in_valid = 1'b1;
      in_data = {hi, lo};
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic wr_rect(input logic [31:0] pos, input logic [31:0] size, input bit msk,
                         input int seed, input int gap, input string req);
    int x0 = pos & (NX - 1);
    int y0 = (pos >> 16) & (NY - 1);
    int w = ext_w(size & 32'hffff);
    int h = ext_h(size >> 16);
    int d0 = done_cnt;
    mask_force = msk;
    do_start(pos, size, 1'b0);
    send_words(x0, y0, w, w * h, seed, msk, gap, 1 << 20);
    while (busy) @(negedge clk);
    @(negedge clk);
    cmp_mem(req);
    check(done_cnt == d0 + 1, "R11", "write done pulses", done_cnt - d0, 1);
  endtask

  task automatic rd_rect(input logic [31:0] pos, input logic [31:0] size, input int gap, input string req);
    int x0 = pos & (NX - 1);
    int y0 = (pos >> 16) & (NY - 1);
    int w = ext_w(size & 32'hffff);
    int h = ext_h(size >> 16);
    int n = w * h;
    int d0 = done_cnt;
    int bad = 0;
    int stall_bad = 0;
    do_start(pos, size, 1'b1);
    check(data_ready === 1'b1, "R9", "data_ready after read start", int'(data_ready), 1);
    for (int k = 0; k < (n + 1) / 2; k++) begin
      logic [31:0] e, d0w;
      e[15:0]  = exp_mem[paddr(x0, y0, w, 2 * k)];
      e[31:16] = (2 * k + 1 < n) ? exp_mem[paddr(x0, y0, w, 2 * k + 1)] : 16'h0000;
      while (!out_valid) @(negedge clk);
      d0w = out_data;
      if (gap != 0) begin
        repeat ((k % 3) * gap) @(negedge clk);
        if (!out_valid || out_data !== d0w) stall_bad++;
      end
      if (out_data !== e) begin
        bad++;
        if (bad == 1) $display("  word %0d got %h expected %h", k, out_data, e);
      end
      if (2 * k + 1 >= n)
        check(out_data[31:16] == 16'h0, "R8", "padding of odd final word", int'(out_data[31:16]), 0);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    check(bad == 0, req, "read word mismatches", bad, 0);
    if (gap != 0) check(stall_bad == 0, "R7", "output changed while stalled", stall_bad, 0);
    while (busy) @(negedge clk);
    @(negedge clk);
    check(data_ready === 1'b0, "R9", "data_ready after read end", int'(data_ready), 0);
    check(done_cnt == d0 + 1, "R11", "read done pulses", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMN; i++) begin
      mem[i] = 16'(((i * 3) ^ 32'h1234) & 32'h7fff);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R12: reset state
    check(busy === 1'b0, "R12", "busy after reset", int'(busy), 0);
    check(in_ready === 1'b0, "R12", "in_ready after reset", int'(in_ready), 0);
    check(out_valid === 1'b0, "R12", "out_valid after reset", int'(out_valid), 0);
    check(data_ready === 1'b0, "R12", "data_ready after reset", int'(data_ready), 0);
    check(done === 1'b0 && mem_we === 1'b0, "R12", "done/mem_we after reset", int'(done | mem_we), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R8: odd-count rectangle, placement and pixel order
    wr_rect(32'h0002_0003, 32'h0003_0005, 1'b0, 1, 0, "R3");
    rd_rect(32'h0002_0003, 32'h0003_0005, 0, "R3");

    // R4 R6 R7: sweep of widths and heights, with stalls on alternate shapes
    for (int w = 1; w <= 6; w++) begin
      for (int h = 1; h <= 3; h++) begin
        int x = (w * 7 + h) % NX;
        int y = (h * 5 + w) % NY;
        logic [31:0] p = 32'((y << 16) | x);
        logic [31:0] s = 32'((h << 16) | w);
        wr_rect(p, s, (h == 2), w * 10 + h, (w + h) % 2, "R6");
        rd_rect(p, s, (w + h + 1) % 2, "R4");
      end
    end

    // R4: wrap across right and bottom edges
    wr_rect(32'h000E_001E, 32'h0004_0005, 1'b0, 77, 1, "R4");
    rd_rect(32'h000E_001E, 32'h0004_0005, 1, "R4");

    // R2 R5: zero fields give the full frame, mask forced
    wr_rect(32'h0000_0000, 32'h0000_0000, 1'b1, 9, 0, "R5");
    rd_rect(32'h0000_0000, 32'h0000_0000, 0, "R2");

    // R1 R2: junk in unused placement and dimension bits
    wr_rect(32'hFFF5_FFE7, 32'hFFE2_FFE3, 1'b0, 21, 0, "R1");
    rd_rect(32'h0005_0007, 32'h0002_0003, 0, "R2");

    // R10: abandon a write after two words, then start another
    begin
      int d0;
      mask_force = 1'b0;
      do_start(32'h0008_000A, 32'h0002_0004, 1'b0);
      send_words(10, 8, 4, 8, 55, 1'b0, 0, 2);
      repeat (4) @(negedge clk);
      check(busy === 1'b1 && in_ready === 1'b1, "R6", "waiting for third word", int'(in_ready), 1);
      d0 = done_cnt;
      wr_rect(32'h0001_0014, 32'h0003_0003, 1'b0, 66, 0, "R10");
      check(done_cnt == d0 + 1, "R10", "done pulses across restart", done_cnt - d0, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule